// File: doc/BRIEF.md
# Local interrupt controller countdown timer

This block is the countdown timer of a per-processor interrupt controller. Software reaches it through a small register port. It can set a divide configuration and load an initial count. It can read back the divide configuration, the initial count and the count that remains. A free-running prescaler makes a base tick every 16 input clocks. A programmable divider then groups base ticks into timer ticks, and every timer tick lowers the count by one.

When the count steps from one to zero, the block sends a one-cycle expiry pulse toward the interrupt logic. The count then rests at zero until software loads a new initial count. A new load waits for the next base-tick boundary before it starts counting, so a countdown never begins in the middle of a base tick. Loading zero halts the timer.

Top module: `apic_countdown_timer`

## Requirements
- R1: The divide ratio is 2 to the power ((S + 1) mod 8), where S is a 3-bit selector with stored configuration bit 3 as its high bit and bits 1:0 as its low bits. Selector 111 divides by 1, 000 by 2, 011 by 16 and 100 by 32.
- R2: Register select 0 is the divide configuration. Only bits 3, 1 and 0 can be written (the write value is ANDed with 0xB), and reads return the stored value with all other bits zero. The reset value is 0.
- R3: One timer tick lasts ratio x 16 input clock cycles.
- R4: A write to register select 1 stores the full 32-bit initial count, reads back the same value, and loads that value into the current count at once.
- R5: The prescaler runs freely from reset. Base-tick boundaries fall at clock edges 15, 31, 47 and so on, counting from 0 at the first edge after reset is released. A countdown starts at the first boundary after the write edge, and each later decrement follows ratio x 16 edges after the previous one.
- R6: Register select 2 reads the current count, and writes to it have no effect. Register select 3 reads as zero.
- R7: The current count reads the number of timer ticks that remain. It resets to 0 and holds at 0 after expiry until the next initial-count write.
- R8: Writing an initial count of zero stops any countdown in progress and no expiry pulse follows.
- R9: The expiry output is high for exactly one cycle: the cycle in which the current count first reads zero after stepping down from one.
- R10: Writing a new initial count while a countdown is running abandons the old countdown. Only the new one produces an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes (0 divide, 1 initial, 2 current) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| expire | output | 1 | One-cycle expiry pulse |

## Verification
The hardest case to reach is the one where a load must wait for a base-tick boundary: the write falls partway through a base tick, and the countdown should start only at the boundary. The prescaler phase cannot be seen at the ports. The bench therefore counts clock edges from reset release and works out the phase of every write from that count. From the phase it predicts the exact edge of each expiry and of each count readback. Writes are placed at several phases, including just before a boundary. A rewrite and a zero write are issued in the middle of a countdown to show that the old expiry never appears.

// File: rtl/apic_countdown_timer.sv
module apic_countdown_timer #(
  parameter int CNT_W    = 32,
  parameter int BASE_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             expire
);
  localparam int PRE_W = $clog2(BASE_DIV);

  logic [PRE_W-1:0] pre_q;
  logic [3:0]       cfg_q;
  logic [CNT_W-1:0] init_q, cur_q;
  logic [7:0]       grp_q;
  logic             pend_q, run_q, expire_q;

  wire       base_tick = (pre_q == PRE_W'(BASE_DIV - 1));
  wire       wr_init   = wr_en && (wr_sel == 2'd1);
  wire [2:0] shift     = {cfg_q[3], cfg_q[1:0]} + 3'd1;
  wire [7:0] grp_last  = (8'd1 << shift) - 8'd1;

  assign expire = expire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      cfg_q    <= '0;
      init_q   <= '0;
      cur_q    <= '0;
      grp_q    <= '0;
      pend_q   <= 1'b0;
      run_q    <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      pre_q    <= base_tick ? '0 : pre_q + 1'b1;
      expire_q <= 1'b0;
      if (wr_en && wr_sel == 2'd0) cfg_q <= wr_data[3:0] & 4'hB;
      if (wr_init) begin
        init_q <= wr_data;
        cur_q  <= wr_data;
        run_q  <= 1'b0;
        pend_q <= (wr_data != '0);
        grp_q  <= '0;
      end else if (base_tick) begin
        if (pend_q) begin
          pend_q <= 1'b0;
          run_q  <= 1'b1;
          grp_q  <= '0;
        end else if (run_q) begin
          if (grp_q >= grp_last) begin
            grp_q <= '0;
            cur_q <= cur_q - 1'b1;
            if (cur_q == CNT_W'(1)) begin
              run_q    <= 1'b0;
              expire_q <= 1'b1;
            end
          end else begin
            grp_q <= grp_q + 8'd1;
          end
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = CNT_W'(cfg_q);
      2'd1:    rd_data = init_q;
      2'd2:    rd_data = cur_q;
      default: rd_data = '0;
    endcase
  end

  assert_expire_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> (cur_q == '0));

  assert_expire_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);

  assert_reload_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_init |=> (cur_q == $past(wr_data)));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_init) |=> $stable(cur_q));

  assert_step_of_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wr_init) |=> (cur_q == $past(cur_q)) || (cur_q == $past(cur_q) - 1'b1));
endmodule

// File: tb/apic_countdown_timer_tb_top.sv
`timescale 1ns/1ps
module apic_countdown_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        expire;

  int n_cmp = 0, n_bad = 0;
  int edge_k = 0;
  int exp_q[$];
  int ratio = 2;
  logic prev_exp = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  apic_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .expire(expire)
  );

  always @(posedge clk) if (rst_n) edge_k <= edge_k + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pops expected expiry edges and compares with observed pulses
  always @(negedge clk) if (rst_n) begin
    if (prev_exp && expire) chk("R9 pulse longer than one cycle", 32'd1, 32'd0);
    if (expire) begin
      if (exp_q.size() == 0) chk("R8/R10 unexpected expiry", 32'(edge_k - 1), 32'hFFFF_FFFF);
      else chk("R3/R5/R9 expiry edge", 32'(edge_k - 1), 32'(exp_q.pop_front()));
    end
    prev_exp = expire;
  end

  task automatic wait_edge(int target);
    while (edge_k < target) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d, output int w);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; w = edge_k;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int start_of(int w);
    int s = w + 1;
    while (s % 16 != 15) s++;
    return s;
  endfunction

  function automatic int ratio_of(logic [3:0] c);
    logic [2:0] sh = {c[3], c[1:0]} + 3'd1;
    return 1 << sh;
  endfunction

  task automatic set_div(logic [3:0] c);
    int w;
    wr(2'd0, {28'd0, c}, w);
    ratio = ratio_of(c & 4'hB);
  endtask

  // driver: loads a count and pushes the predicted expiry edge
  task automatic load(int n, output int s);
    int w;
    wr(2'd1, n, w);
    s = start_of(w);
    exp_q.delete();
    if (n != 0) exp_q.push_back(s + ratio * 16 * n);
  endtask

  task automatic rd(logic [1:0] sel, logic [31:0] exp, string req);
    rd_sel = sel; #0.1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int s, e, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(2'd0, 0, "R2 reset divide cfg");
    rd(2'd1, 0, "R4 reset initial count");
    rd(2'd2, 0, "R7 reset current count");
    chk("R9 reset expire", {31'd0, expire}, 0);

    // R2: mask 0xB
    set_div(4'hF);
    wr(2'd0, 32'hFFFF_FFFF, w);
    rd(2'd0, 32'hB, "R2 masked write");
    rd(2'd3, 0, "R6 select 3 reads zero");

    // R1/R3/R5: ratio 1, count 3, mid-tick write
    wait_edge(21);
    load(3, s);
    rd(2'd1, 3, "R4 initial readback");
    rd(2'd2, 3, "R4 current loaded");
    wr(2'd2, 32'd99, w);
    rd(2'd2, 3, "R6 current write ignored");
    wait_edge(s + 16 + 1);
    rd(2'd2, 2, "R7 remaining after one tick");
    wait_edge(s + 16 * 3 - 1 + 1);
    rd(2'd2, 1, "R3 count before final tick");
    e = s + 16 * 3;
    wait_edge(e + 2);
    chk("R9 expiry seen", exp_q.size(), 0);
    wait_edge(e + 60);
    rd(2'd2, 0, "R7 holds zero after expiry");

    // R1: code 000 -> 2, write just before a boundary
    set_div(4'h0);
    wait_edge(((edge_k / 16) + 1) * 16 + 14);
    load(2, s);
    wait_edge(s + 2 * 16 * 2 + 2);
    chk("R1 div2 expiry", exp_q.size(), 0);

    // R1: code 100 -> 32
    set_div(4'h8);
    load(1, s);
    wait_edge(s + 32 * 16 - 1 + 1);
    rd(2'd2, 1, "R1 div32 not yet expired");
    wait_edge(s + 32 * 16 + 2);
    chk("R1 div32 expiry", exp_q.size(), 0);

    // R1: code 011 -> 16
    set_div(4'h3);
    load(2, s);
    wait_edge(s + 16 * 16 + 1);
    rd(2'd2, 1, "R1 div16 one tick gone");
    wait_edge(s + 16 * 16 * 2 + 2);
    chk("R1 div16 expiry", exp_q.size(), 0);

    // R8: zero write stops a running countdown
    set_div(4'hB);
    load(4, s);
    wait_edge(s + 20);
    load(0, s);
    rd(2'd2, 0, "R8 zero write clears count");
    wait_edge(edge_k + 200);
    rd(2'd2, 0, "R8 timer stays stopped");

    // R10: rewrite mid-run
    load(10, s);
    wait_edge(s + 40);
    load(2, s);
    rd(2'd2, 2, "R10 reloaded count");
    wait_edge(s + 16 * 10 + 50);
    chk("R10 only new expiry", exp_q.size(), 0);
    rd(2'd2, 0, "R10 zero after new expiry");

    finish_run();
  end
endmodule